// File: doc/BRIEF.md
# Compare-Match Event Timer

A counter of configurable width that steps once for each pulse of a slow tick enable. Software reaches it through a word-addressed register bus with single-cycle access. The counter runs in the system clock domain. A separate block has already synchronised the slow sleep clock and reduced it to a one-cycle `tick_en` pulse.

Software arms a one-shot event in three writes:

1. Write 1 to the clear register to zero the count.
2. Load the requested delta into the match register.
3. Write the control register with only the run bit set.

When the count reaches the match value, `irq` rises and stays high. It stays high until software stops the timer or clears the count, so every event gives the consumer a clean rising edge. A clear-on-match bit returns the count to zero at the event instead.

Top module: `evt_timer`

## Requirements
- R1: A synchronous active-high `rst` zeroes the match, count and control registers and holds `irq` low.
- R2: Word offsets follow this map:
  - Offset 0 is the match register. It reads back all bits that were written.
  - Offset 1 is the count.
  - Offset 2 is the control register. Bit 0 is run and bit 1 is clear-on-match. It reads back only these two bits, with the upper bits zero.
  - Offset 3 is the clear register. It always reads 0.
- R3: The count increases by exactly one in a cycle where `tick_en` is 1 and the run bit is 1. It is otherwise unchanged. A control write takes effect from the following cycle.
- R4: Writes to the count offset are ignored.
- R5: A write to offset 3 with data bit 0 equal to 1 zeroes the count. A write there with bit 0 equal to 0 has no effect. The clear is not held: the count resumes on the next tick.
- R6: A counted tick that makes the count equal the match value is a match event. A match event sets `irq`, and `irq` then stays high.
- R7: `irq` goes low one cycle after either of two writes: a write to offset 2 with bit 0 equal to 0, or a write to offset 3 with bit 0 equal to 1. This clearing takes priority over a match event in the same cycle.
- R8: With clear-on-match set, a match event sets `irq` and leaves the count at zero instead of the match value.
- R9: With clear-on-match clear, the count keeps advancing past the match value, wrapping modulo 2^W.
- R10: A clear write in the same cycle as a tick wins: the count becomes 0 and no match event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per slow tick |
| bus_addr | input | 2 | Register word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Event line, high from match until stopped or cleared |

## Verification
The hardest situations to reach from the ports are bus writes that coincide with the tick that would cause a match. Examples are a stop write or a clear write in exactly that cycle, where the priority of R7 and R10 decides the result. Directed sequences place these collisions deliberately. A long random phase then draws small match values, frequent ticks and sparse writes to all four offsets. This makes such overlaps recur, and each cycle is compared against a bench model of the requirements.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [1:0]   bus_addr,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  localparam logic [1:0] OFS_MATCH = 2'd0;
  localparam logic [1:0] OFS_COUNT = 2'd1;
  localparam logic [1:0] OFS_CTRL  = 2'd2;
  localparam logic [1:0] OFS_CLR   = 2'd3;

  logic [W-1:0] match_q, cnt_q;
  logic         run_q, com_q, irq_q;

  wire          wr_clr  = bus_we && (bus_addr == OFS_CLR) && bus_wdata[0];
  wire          wr_stop = bus_we && (bus_addr == OFS_CTRL) && !bus_wdata[0];
  wire [W-1:0]  cnt_inc = cnt_q + 1'b1;
  wire          step    = run_q && tick_en && !wr_clr;
  wire          hit     = step && (cnt_inc == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      com_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_clr)
        cnt_q <= '0;
      else if (step)
        cnt_q <= (hit && com_q) ? '0 : cnt_inc;
      if (bus_we && bus_addr == OFS_MATCH)
        match_q <= bus_wdata;
      if (bus_we && bus_addr == OFS_CTRL) begin
        run_q <= bus_wdata[0];
        com_q <= bus_wdata[1];
      end
      if (wr_clr || wr_stop)
        irq_q <= 1'b0;
      else if (hit)
        irq_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MATCH: bus_rdata = match_q;
      OFS_COUNT: bus_rdata = cnt_q;
      OFS_CTRL:  bus_rdata = {{(W-2){1'b0}}, com_q, run_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;
endmodule

module evt_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic [1:0]   bus_addr,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic         irq,
  input logic [W-1:0] cnt_q,
  input logic         run_q
);
  a_r1_reset: assert property (@(posedge clk) rst |=> (cnt_q == '0) && !irq);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !(bus_we && bus_addr == 2'd3)) |=> $stable(cnt_q));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd3 && bus_wdata[0]) |=> (cnt_q == '0));

  a_r7_stop_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2 && !bus_wdata[0]) |=> !irq);

  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(tick_en) && $past(run_q)));
endmodule

bind evt_timer evt_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_wdata(bus_wdata), .irq(irq),
  .cnt_q(cnt_q), .run_q(run_q)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_match, m_cnt;
  logic        m_run, m_com, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer #(.W(32)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_match;
      2'd1:    return m_cnt;
      2'd2:    return {30'd0, m_com, m_run};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_update(input logic we, input logic [1:0] a,
                              input logic [31:0] d, input logic tk);
    logic clr, stop, ev;
    logic [31:0] nxt;
    clr  = we && a == 2'd3 && d[0];
    stop = we && a == 2'd2 && !d[0];
    ev   = 1'b0;
    if (clr) m_cnt = 32'd0;
    else if (m_run && tk) begin
      nxt = m_cnt + 32'd1;
      ev  = (nxt == m_match);
      m_cnt = (ev && m_com) ? 32'd0 : nxt;
    end
    if (clr || stop) m_irq = 1'b0;
    else if (ev) m_irq = 1'b1;
    if (we && a == 2'd0) m_match = d;
    if (we && a == 2'd2) begin m_run = d[0]; m_com = d[1]; end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic tk, input string tag);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1;
    if (!we) check(tag, bus_rdata, model_read(a));
    @(posedge clk);
    model_update(we, a, d, tk);
    #1;
    check(tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(1'b0, a, 32'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic tick(input string tag);
    step(1'b0, 2'd1, 32'd0, 1'b1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_match = '0; m_cnt = '0; m_run = 0; m_com = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd(i[1:0], "R1");
    check("R1", {31'd0, irq}, 32'd0);
    // R2 register map
    wr(2'd0, 32'hA5C3_0F96, "R2"); rd(2'd0, "R2");
    wr(2'd2, 32'hFFFF_FFFF, "R2"); rd(2'd2, "R2"); check("R2", bus_rdata, 32'd3);
    wr(2'd2, 32'd0, "R2"); rd(2'd3, "R2");
    // R4 count write ignored
    wr(2'd1, 32'h55, "R4"); rd(2'd1, "R4"); check("R4", bus_rdata, 32'd0);
    // R3 tick without run
    tick("R3"); rd(2'd1, "R3"); check("R3", bus_rdata, 32'd0);
    // arm one-shot
    wr(2'd3, 32'd1, "R5"); wr(2'd3, 32'd0, "R5");
    wr(2'd0, 32'd5, "R6"); wr(2'd2, 32'd1, "R6");
    for (int i = 0; i < 5; i++) begin
      tick("R3"); rd(2'd1, "R3"); rd(2'd1, "R3");
    end
    check("R6", {31'd0, irq}, 32'd1);
    check("R6", bus_rdata, 32'd5);
    // R9 runs past match
    tick("R9"); tick("R9"); rd(2'd1, "R9"); check("R9", bus_rdata, 32'd7);
    // R5 clear with bit0=0 has no effect, bit0=1 clears, not held
    wr(2'd3, 32'd2, "R5"); rd(2'd1, "R5"); check("R5", bus_rdata, 32'd7);
    check("R7", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'd0, "R7"); check("R7", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'd1, "R5");
    wr(2'd3, 32'd1, "R5"); rd(2'd1, "R5"); check("R5", bus_rdata, 32'd0);
    tick("R5"); rd(2'd1, "R5"); check("R5", bus_rdata, 32'd1);
    // R8 clear-on-match
    wr(2'd3, 32'd1, "R8"); wr(2'd0, 32'd3, "R8"); wr(2'd2, 32'd3, "R8");
    tick("R8"); tick("R8"); tick("R8");
    check("R8", {31'd0, irq}, 32'd1);
    rd(2'd1, "R8"); check("R8", bus_rdata, 32'd0);
    wr(2'd3, 32'd1, "R7"); check("R7", {31'd0, irq}, 32'd0);
    // R7 stop in same cycle as matching tick
    wr(2'd2, 32'd1, "R7"); tick("R7"); tick("R7");
    step(1'b1, 2'd2, 32'd0, 1'b1, "R7"); check("R7", {31'd0, irq}, 32'd0);
    // R10 clear write coinciding with matching tick
    wr(2'd3, 32'd1, "R10"); wr(2'd2, 32'd1, "R10"); tick("R10"); tick("R10");
    step(1'b1, 2'd3, 32'd1, 1'b1, "R10");
    check("R10", {31'd0, irq}, 32'd0);
    rd(2'd1, "R10"); check("R10", bus_rdata, 32'd0);
    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      logic we; logic [1:0] a; logic [31:0] d;
      we = ($urandom_range(0, 7) == 0);
      a  = 2'($urandom_range(0, 3));
      d  = (a == 2'd0) ? 32'($urandom_range(0, 12)) : 32'($urandom_range(0, 3));
      step(we, a, d, ($urandom_range(0, 2) != 0), "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule